// File: doc/BRIEF.md
# Chained Receive Status Interrupt Controller

This block sits between software and a receive engine. It holds up to two queued receive enables. Each enable names the buffer page that its packet should land in. The oldest enable is the one the receive engine services, and its page appears on `activePage`.

When a reception ends, the block raises a sticky completion flag and records the page that was filled. It drives an interrupt from that flag through a mask bit. If a second reception completes while the first result is still unacknowledged, the second result is parked. It is shown only after software clears the first one, and only after the interrupt line has stayed low for a guaranteed gap.

Software talks to the block through a small command port with three operations: enable, clear and disable. The receive engine reports with one-cycle `pktStart` and `pktDone` strobes. The status outputs can be read at any time and have no side effects.

Top module: `rx_chain_irq`

## Requirements
- R1: After reset the queue is empty (`qCount`=0, `activeValid`=0, `activePage`=0). `rxIdle` is 1, and `rxDoneFlag`, `irq` and `overflowErr` are 0.
- R2: A command with `cmdValid`=1 and `cmdOp`=2'b01 (enable) appends `cmdPage` to the queue. `qCount` gives the occupancy (0, 1 or 2), and `activePage` shows the page of the oldest entry.
- R3: An enable issued while two entries are queued is dropped and the queue contents are unchanged. It sets `overflowErr`, which stays 1 until reset.
- R4: A `pktDone` that ends a begun reception removes the oldest entry, so the next queued page becomes active. If `rxDoneFlag` was 0, it sets `rxDoneFlag` and puts the finished page on `donePage`.
- R5: Only a clear command (`cmdOp`=2'b10) lowers `rxDoneFlag` and `irq`. Enable and disable commands leave them unchanged.
- R6: A completion that arrives while `rxDoneFlag` is 1 is held back, and `donePage` keeps the first page. After the clear, `rxDoneFlag` stays 0 for GAP_CYC cycles (4 by default). It then rises with the held page.
- R7: `irq` equals `rxDoneFlag` AND NOT `rxMaskInhibit`. `rxIdle` is 1 exactly when the queue is empty, whatever the mask is.
- R8: A disable command (`cmdOp`=2'b11) removes the oldest entry when its reception has not begun. Two disables therefore empty a queue of two entries that have not begun.
- R9: A disable while the oldest reception has begun leaves that entry in place. It removes the second entry if there is one, and otherwise does nothing.
- R10: `pktStart` is ignored while the queue is empty or a completion is held back. `pktDone` is ignored when no reception has begun.
- R11: A command with `cmdOp`=2'b00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 00 none, 01 enable, 10 clear, 11 disable |
| cmdPage | input | PAGE_W | Target page for enable |
| rxMaskInhibit | input | 1 | Masks the completion flag from `irq` |
| pktStart | input | 1 | Receive engine began a packet |
| pktDone | input | 1 | Receive engine finished a packet |
| activePage | output | PAGE_W | Page of the oldest queued enable, 0 when empty |
| activeValid | output | 1 | Queue not empty |
| qCount | output | 2 | Queue occupancy |
| rxIdle | output | 1 | No enable queued |
| rxDoneFlag | output | 1 | Completion flag |
| donePage | output | PAGE_W | Page of the completion being reported |
| overflowErr | output | 1 | Sticky enable-overflow error |
| irq | output | 1 | Interrupt line |

## Verification
The bench queues two completions and then clears. It counts the low cycles of the flag exactly, which catches a design that shows the second result at once or overwrites the first page. A disable during a begun reception checks that the active entry survives; a design that drops the wrong entry would lose page 0x81. A third enable is checked to see that it neither overwrites a slot nor escapes the sticky error. Start and done strobes are sent with nothing to act on, and the bench confirms that no phantom reception later pops the queue.

// File: rtl/rx_chain_pkg.sv
package rx_chain_pkg;
  localparam int CNT_W = 2;
  localparam int SLOTS = 2;
  localparam logic [CNT_W-1:0] Q_FULL = CNT_W'(SLOTS);

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_ENABLE  = 2'b01,
    OP_CLEAR   = 2'b10,
    OP_DISABLE = 2'b11
  } rxOp_e;

  typedef struct packed {
    logic pop;
    logic toTri;
    logic toPend;
    logic cancelHead;
    logic cancelNext;
    logic push;
    logic reject;
    logic clearTri;
    logic promote;
  } rxStrobe_t;
endpackage

// File: rtl/rx_chain_ctrl.sv
module rx_chain_ctrl
  import rx_chain_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             pktStart,
  input  logic             pktDone,
  input  logic [CNT_W-1:0] qCount,
  input  logic             triSet,
  input  logic             pendSet,
  output rxStrobe_t        strb
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC);

  logic             busy;
  logic [GAP_W-1:0] gapCnt;
  logic             rxBegin, rxEnd, begunEff, gapLoad;
  logic             opEn, opClr, opDis;
  logic [CNT_W-1:0] cntAfter;
  rxOp_e            op;

  always_comb begin
    op       = rxOp_e'(cmdOp);
    opEn     = cmdValid && (op == OP_ENABLE);
    opClr    = cmdValid && (op == OP_CLEAR);
    opDis    = cmdValid && (op == OP_DISABLE);
    rxBegin  = pktStart && (qCount != '0) && !busy && !pendSet;
    rxEnd    = pktDone && busy;
    cntAfter = qCount - {{(CNT_W-1){1'b0}}, rxEnd};
    begunEff = (busy && !rxEnd) || rxBegin;

    strb            = '0;
    strb.pop        = rxEnd;
    strb.toTri      = rxEnd && !triSet;
    strb.toPend     = rxEnd && triSet;
    strb.push       = opEn && (cntAfter != Q_FULL);
    strb.reject     = opEn && (cntAfter == Q_FULL);
    strb.cancelHead = opDis && !begunEff && (cntAfter != '0);
    strb.cancelNext = opDis && begunEff && (cntAfter == Q_FULL);
    strb.clearTri   = opClr;
    strb.promote    = (gapCnt == GAP_W'(1));
    gapLoad         = opClr && (gapCnt == '0) && (pendSet || (rxEnd && triSet));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      gapCnt <= '0;
    end else begin
      if (rxBegin)    busy <= 1'b1;
      else if (rxEnd) busy <= 1'b0;
      if (gapLoad)             gapCnt <= GAP_LOAD;
      else if (gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
    end
  end

  // R6: flag must stay low while the inter-interrupt gap runs
  p_gap_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt != '0) |-> !triSet);

  // R10: a begun reception always owns a queue slot
  p_busy_has_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (qCount != '0));
endmodule

// File: rtl/rx_chain_dp.sv
module rx_chain_dp
  import rx_chain_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strb,
  input  logic [PAGE_W-1:0] cmdPage,
  output logic [CNT_W-1:0] qCount,
  output logic [PAGE_W-1:0] headPage,
  output logic             triFlag,
  output logic             pendFlag,
  output logic [PAGE_W-1:0] donePage,
  output logic             overflowErr
);
  logic [PAGE_W-1:0] slotPage [SLOTS];
  logic [PAGE_W-1:0] nPage    [SLOTS];
  logic [CNT_W-1:0]  cnt, nCnt;
  logic [PAGE_W-1:0] pendPage;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) nPage[i] = slotPage[i];
    nCnt = cnt;
    if (strb.pop) begin
      for (int i = 0; i < SLOTS - 1; i++) nPage[i] = nPage[i+1];
      nCnt = nCnt - 1'b1;
    end
    if (strb.cancelHead) begin
      for (int i = 0; i < SLOTS - 1; i++) nPage[i] = nPage[i+1];
      nCnt = nCnt - 1'b1;
    end
    if (strb.cancelNext) nCnt = nCnt - 1'b1;
    if (strb.push) begin
      for (int i = 0; i < SLOTS; i++)
        if (nCnt == CNT_W'(i)) nPage[i] = cmdPage;
      nCnt = nCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotPage[i] <= '0;
      cnt         <= '0;
      triFlag     <= 1'b0;
      pendFlag    <= 1'b0;
      donePage    <= '0;
      pendPage    <= '0;
      overflowErr <= 1'b0;
    end else begin
      for (int i = 0; i < SLOTS; i++) slotPage[i] <= nPage[i];
      cnt <= nCnt;
      if (strb.reject) overflowErr <= 1'b1;
      if (strb.promote) begin
        triFlag  <= 1'b1;
        donePage <= pendPage;
        pendFlag <= 1'b0;
      end else begin
        if (strb.clearTri) triFlag <= 1'b0;
        if (strb.toTri) begin
          triFlag  <= 1'b1;
          donePage <= slotPage[0];
        end
        if (strb.toPend) begin
          pendFlag <= 1'b1;
          pendPage <= slotPage[0];
        end
      end
    end
  end

  assign qCount   = cnt;
  assign headPage = (cnt != '0) ? slotPage[0] : '0;

  // R3: occupancy never exceeds the two slots
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= Q_FULL);

  // R3: a dropped enable leaves the queue full and the error raised
  p_reject_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> (qCount == Q_FULL) && overflowErr);

  // R3: error is sticky until reset
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R5: only the clear strobe lowers the flag
  p_tri_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (triFlag && !strb.clearTri) |=> triFlag);

  // R6: a held completion waits for the gap to finish
  p_pend_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlag && !strb.promote) |=> pendFlag);
endmodule

// File: rtl/rx_chain_irq.sv
module rx_chain_irq
  import rx_chain_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [PAGE_W-1:0] cmdPage,
  input  logic              rxMaskInhibit,
  input  logic              pktStart,
  input  logic              pktDone,
  output logic [PAGE_W-1:0] activePage,
  output logic              activeValid,
  output logic [1:0]        qCount,
  output logic              rxIdle,
  output logic              rxDoneFlag,
  output logic [PAGE_W-1:0] donePage,
  output logic              overflowErr,
  output logic              irq
);
  rxStrobe_t        strb;
  logic [CNT_W-1:0] cnt;
  logic             triFlag, pendFlag;

  rx_chain_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .pktStart(pktStart), .pktDone(pktDone), .qCount(cnt),
    .triSet(triFlag), .pendSet(pendFlag), .strb(strb)
  );

  rx_chain_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdPage(cmdPage),
    .qCount(cnt), .headPage(activePage), .triFlag(triFlag),
    .pendFlag(pendFlag), .donePage(donePage), .overflowErr(overflowErr)
  );

  assign qCount      = cnt;
  assign activeValid = (cnt != '0);
  assign rxIdle      = (cnt == '0);
  assign rxDoneFlag  = triFlag;
  assign irq         = triFlag && !rxMaskInhibit;

  // R7: masked flag never reaches the line
  p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxMaskInhibit |-> !irq);
endmodule

// File: tb/rx_chain_irq_bench.sv
module rx_chain_irq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [7:0] cmdPage = 8'h00;
  logic       rxMaskInhibit = 1'b0;
  logic       pktStart = 1'b0;
  logic       pktDone = 1'b0;
  logic [7:0] activePage, donePage;
  logic       activeValid, rxIdle, rxDoneFlag, overflowErr, irq;
  logic [1:0] qCount;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  rx_chain_irq u_rx_chain_irq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPage(cmdPage), .rxMaskInhibit(rxMaskInhibit), .pktStart(pktStart),
    .pktDone(pktDone), .activePage(activePage), .activeValid(activeValid),
    .qCount(qCount), .rxIdle(rxIdle), .rxDoneFlag(rxDoneFlag),
    .donePage(donePage), .overflowErr(overflowErr), .irq(irq)
  );

  typedef struct packed {
    logic       cv;
    logic [1:0] op;
    logic [7:0] pg;
    logic       st;
    logic       dn;
    logic       mk;
    logic [1:0] eCnt;
    logic [7:0] ePg;
    logic       eTri;
    logic       eIrq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd1, 8'h11, 1'b0, 1'b0, 1'b0, 2'd1, 8'h11, 1'b0, 1'b0},
    '{1'b1, 2'd1, 8'h22, 1'b0, 1'b0, 1'b0, 2'd2, 8'h11, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd2, 8'h11, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 8'h22, 1'b1, 1'b1},
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd1, 8'h22, 1'b1, 1'b0},
    '{1'b1, 2'd1, 8'h33, 1'b0, 1'b0, 1'b0, 2'd2, 8'h22, 1'b1, 1'b1},
    '{1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 8'h22, 1'b0, 1'b0},
    '{1'b1, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 8'h33, 1'b0, 1'b0},
    '{1'b1, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{"R2", "R2", "R10", "R4", "R7", "R5",
                                 "R5", "R8", "R8", "R10", "R10"};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic cv, input logic [1:0] op, input logic [7:0] pg,
                     input logic st, input logic dn);
    cmdValid = cv; cmdOp = op; cmdPage = pg; pktStart = st; pktDone = dn;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00; pktStart = 1'b0; pktDone = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1", "qCount", qCount, 0);
    chk("R1", "activeValid", activeValid, 0);
    chk("R1", "activePage", activePage, 0);
    chk("R1", "rxIdle", rxIdle, 1);
    chk("R1", "rxDoneFlag", rxDoneFlag, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "overflowErr", overflowErr, 0);

    for (int v = 0; v < NV; v++) begin
      rxMaskInhibit = TBL[v].mk;
      cyc(TBL[v].cv, TBL[v].op, TBL[v].pg, TBL[v].st, TBL[v].dn);
      chk(TAG[v], "qCount", qCount, TBL[v].eCnt);
      chk(TAG[v], "activePage", activePage, TBL[v].ePg);
      chk(TAG[v], "rxDoneFlag", rxDoneFlag, TBL[v].eTri);
      chk(TAG[v], "irq", irq, TBL[v].eIrq);
    end
    chk("R4", "donePage", donePage, 8'h11);
    rxMaskInhibit = 1'b0;

    // R6 held second completion and gap
    cyc(1, 2'd1, 8'h55, 0, 0);
    cyc(1, 2'd1, 8'h66, 0, 0);
    cyc(0, 2'd0, 8'h00, 1, 0);
    cyc(0, 2'd0, 8'h00, 0, 1);
    chk("R4", "donePage first", donePage, 8'h55);
    chk("R4", "activePage next", activePage, 8'h66);
    cyc(0, 2'd0, 8'h00, 1, 0);
    cyc(0, 2'd0, 8'h00, 0, 1);
    chk("R6", "flag held", rxDoneFlag, 1);
    chk("R6", "donePage kept", donePage, 8'h55);
    chk("R6", "qCount", qCount, 0);
    // R10 start ignored while a completion is held
    cyc(1, 2'd1, 8'h77, 0, 0);
    cyc(0, 2'd0, 8'h00, 1, 0);
    cyc(0, 2'd0, 8'h00, 0, 1);
    chk("R10", "qCount no pop", qCount, 1);
    chk("R10", "activePage", activePage, 8'h77);
    cyc(1, 2'd2, 8'h00, 0, 0);
    chk("R6", "gap low 1", rxDoneFlag, 0);
    chk("R6", "gap irq 1", irq, 0);
    for (int g = 2; g <= 4; g++) begin
      cyc(0, 2'd0, 8'h00, 0, 0);
      chk("R6", "gap low", rxDoneFlag, 0);
    end
    cyc(0, 2'd0, 8'h00, 0, 0);
    chk("R6", "second flag", rxDoneFlag, 1);
    chk("R6", "second page", donePage, 8'h66);
    chk("R6", "second irq", irq, 1);
    cyc(1, 2'd2, 8'h00, 0, 0);
    chk("R5", "clear", rxDoneFlag, 0);

    // R3 overflow
    doReset();
    cyc(1, 2'd1, 8'hA1, 0, 0);
    cyc(1, 2'd1, 8'hA2, 0, 0);
    cyc(1, 2'd1, 8'hA3, 0, 0);
    chk("R3", "qCount", qCount, 2);
    chk("R3", "overflowErr", overflowErr, 1);
    chk("R3", "activePage", activePage, 8'hA1);
    cyc(1, 2'd3, 8'h00, 0, 0);
    chk("R3", "second slot kept", activePage, 8'hA2);
    cyc(1, 2'd3, 8'h00, 0, 0);
    chk("R8", "emptied", qCount, 0);
    chk("R3", "sticky", overflowErr, 1);
    doReset();
    chk("R1", "err cleared", overflowErr, 0);

    // R9 disable with begun head
    cyc(1, 2'd1, 8'h81, 0, 0);
    cyc(1, 2'd1, 8'h82, 0, 0);
    cyc(0, 2'd0, 8'h00, 1, 0);
    cyc(1, 2'd3, 8'h00, 0, 0);
    chk("R9", "qCount", qCount, 1);
    chk("R9", "activePage", activePage, 8'h81);
    cyc(1, 2'd3, 8'h00, 0, 0);
    chk("R9", "head survives", activePage, 8'h81);
    cyc(0, 2'd0, 8'h00, 0, 1);
    chk("R9", "completed", rxDoneFlag, 1);
    chk("R9", "donePage", donePage, 8'h81);
    chk("R9", "qCount end", qCount, 0);

    // R7 / R11
    doReset();
    rxMaskInhibit = 1'b1;
    chk("R7", "rxIdle masked", rxIdle, 1);
    cyc(1, 2'd0, 8'h99, 0, 0);
    chk("R11", "no-op qCount", qCount, 0);
    chk("R11", "no-op flag", rxDoneFlag, 0);
    cyc(1, 2'd1, 8'h99, 0, 0);
    chk("R7", "rxIdle busy", rxIdle, 0);
    cyc(0, 2'd0, 8'h00, 1, 0);
    cyc(0, 2'd0, 8'h00, 0, 1);
    chk("R7", "flag under mask", rxDoneFlag, 1);
    chk("R7", "irq masked", irq, 0);
    chk("R7", "rxIdle after", rxIdle, 1);
    rxMaskInhibit = 1'b0;
    #1;
    chk("R7", "irq unmasked", irq, 1);

    finishRun();
  end
endmodule